// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 16-bit virtual address into a 10-bit physical address by walking two levels of translation tables held in physical memory. A client presents a virtual address together with the physical base of the top-level table (the directory). The walker fetches one directory entry, uses the frame number it holds to locate a second-level table, fetches one entry from that table, and combines the frame number found there with the page offset of the virtual address. A missing mapping at either level ends the walk early with a fault indication.

Memory is reached through a single 16-bit read port with a request/acknowledge handshake, so the walker works with a memory of any latency. Pages are 64 bytes, each table fills exactly one page, and each entry is two bytes, which gives 32 entries per table. The client performs the final data access itself, using the physical address that the walker returns.

Top module: `xlate_walker`

## Requirements
- R1: While reset is held and after its release, the walker is idle with `req_ready` at 1 and `rd_en`, `done`, `fault` and `paddr` all at 0.
- R2: A request is taken only at a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while no walk is in progress, and `req_valid`, `req_vaddr` and `dir_base` have no effect during a walk.
- R3: The first read after a request goes to the address made of `dir_base[9:6]` followed by six bits holding twice `req_vaddr[15:11]`. The six low bits of `dir_base` are ignored, so every entry address is even.
- R4: `rd_en` and `rd_addr` stay constant from the cycle a read starts until the cycle in which `rd_ack` is 1, and `rd_data` is taken in that cycle. `rd_data[15:8]` holds the byte at `rd_addr` and `rd_data[7:0]` holds the byte at `rd_addr`+1.
- R5: A directory entry with bit 15 set leads to a second read, at an address made of that entry's bits [3:0] followed by six bits holding twice `req_vaddr[10:6]`.
- R6: A second-level entry with bit 15 set ends the walk. In the next cycle `done` is 1 for one cycle, `fault` is 0, and `paddr` is the entry's bits [3:0] followed by `req_vaddr[5:0]`.
- R7: An entry with bit 15 clear at either level ends the walk. In the next cycle `done` and `fault` are both 1 for one cycle and `paddr` is 0. No further read is made for that request.
- R8: Entry bits [14:4] are ignored at both levels.
- R9: `paddr` changes only in a cycle where `done` is 1, and `fault` is 0 whenever `done` is 0.
- R10: `done` is never 1 in two consecutive cycles, and a new request can be taken at the edge that ends the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address to translate |
| dir_base | input | 10 | Physical base of the directory (low six bits ignored) |
| req_ready | output | 1 | Walker idle and able to take a request |
| rd_en | output | 1 | Entry read outstanding |
| rd_addr | output | 10 | Byte address of the entry being read |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 16 | Entry word, lower-addressed byte in bits [15:8] |
| done | output | 1 | One-cycle pulse at the end of a walk |
| fault | output | 1 | With done: the walk found an unmapped level |
| paddr | output | 10 | Translated physical address, held until the next walk ends |

## Verification
The bench builds the walker with its default geometry: a 5/5/6 split of the virtual address, 10-bit physical addresses and 16-bit entries. With these values every directory and table index, including 0 and 31, and every frame number can be reached within a small byte-array memory. The memory model answers each read after a latency of 0 to 3 cycles that is chosen per request. This exercises both the immediate acknowledge and a read held over several cycles. Randomly filled memory produces valid and invalid entries at both levels with arbitrary reserved bits, and requests held high through a walk with changed contents test that the walker ignores them.

// File: rtl/xw_pkg.sv
// Package: shared types for the two-level translation walker.
// Assumes nothing beyond being compiled before the modules that import it.
package xw_pkg;

    // Walk phase: waiting for a request, reading the directory, reading the table.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_DIR  = 2'd1,
        WS_TBL  = 2'd2
    } walk_state_t;

endpackage

// File: rtl/xw_entry_addr.sv
// Module: xw_entry_addr
// Forms the byte address of a table entry from the frame holding the table
// and the index into it. Entries are two bytes wide.
// Assumes tables are page aligned and that IDX_W + 1 <= OFF_W, so that twice
// the index always fits in the page offset and no carry reaches the frame bits.
module xw_entry_addr #(
    parameter int IDX_W = 5,
    parameter int OFF_W = 6,
    parameter int PA_W  = 10
) (
    input  logic [PA_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]      idx,
    output logic [PA_W-1:0]       addr
);
    localparam int FRAME_W = PA_W - OFF_W;

    logic [OFF_W-1:0] entry_off;

    // Scale the index by the entry size and place it under the frame bits.
    always_comb begin
        entry_off = OFF_W'({idx, 1'b0});
        addr      = {frame[FRAME_W-1:0], entry_off};
    end
endmodule

// File: rtl/xw_ctrl.sv
// Module: xw_ctrl
// Sequences one walk: it captures a request, waits for the directory entry,
// then for the table entry, and registers the result or the fault.
// Assumes rd_data is meaningful only in a cycle where rd_ack is 1 and that
// the memory keeps the handshake open until it answers.
module xw_ctrl
    import xw_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int OFF_W = 6,
    parameter int PA_W  = 10,
    parameter int PTE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PA_W-1:0]       dir_base,
    input  logic                  rd_ack,
    input  logic [PTE_W-1:0]      rd_data,
    output walk_state_t           state,
    output logic [VA_W-1:0]       va_q,
    output logic [PA_W-OFF_W-1:0] dir_frame_q,
    output logic [PA_W-OFF_W-1:0] tbl_frame_q,
    output logic                  done,
    output logic                  fault,
    output logic [PA_W-1:0]       paddr
);
    localparam int FRAME_W   = PA_W - OFF_W;
    localparam int VALID_BIT = PTE_W - 1;

    logic entry_valid;
    logic unused_bits;

    // Split the returned entry into its valid flag; the reserved bits and the
    // low bits of the base are deliberately left unconnected.
    always_comb begin
        entry_valid = rd_data[VALID_BIT];
        unused_bits = ^{rd_data[VALID_BIT-1:FRAME_W], dir_base[OFF_W-1:0]};
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= WS_IDLE;
            va_q        <= '0;
            dir_frame_q <= '0;
            tbl_frame_q <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            paddr       <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q        <= req_vaddr;
                        dir_frame_q <= dir_base[PA_W-1:OFF_W];
                        state       <= WS_DIR;
                    end
                end
                WS_DIR: begin
                    if (rd_ack) begin
                        if (entry_valid) begin
                            tbl_frame_q <= rd_data[FRAME_W-1:0];
                            state       <= WS_TBL;
                        end else begin
                            done  <= 1'b1;
                            fault <= 1'b1;
                            paddr <= '0;
                            state <= WS_IDLE;
                        end
                    end
                end
                WS_TBL: begin
                    if (rd_ack) begin
                        done  <= 1'b1;
                        state <= WS_IDLE;
                        if (entry_valid) begin
                            paddr <= {rd_data[FRAME_W-1:0], va_q[OFF_W-1:0]};
                        end else begin
                            fault <= 1'b1;
                            paddr <= '0;
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlate_walker.sv
// Module: xlate_walker (top)
// Translates a virtual address through a directory and one second-level
// table, reading one entry per level over a request/acknowledge port.
// Assumes VA_W = 2*IDX_W + OFF_W and IDX_W + 1 <= OFF_W.
module xlate_walker
    import xw_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int IDX_W = 5,
    parameter int OFF_W = 6,
    parameter int PA_W  = 10,
    parameter int PTE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  dir_base,
    output logic             req_ready,
    output logic             rd_en,
    output logic [PA_W-1:0]  rd_addr,
    input  logic             rd_ack,
    input  logic [PTE_W-1:0] rd_data,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  paddr
);
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int LEVELS  = 2;

    walk_state_t        state;
    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;

    logic [FRAME_W-1:0] lvl_frame [LEVELS];
    logic [IDX_W-1:0]   lvl_idx   [LEVELS];
    logic [PA_W-1:0]    lvl_addr  [LEVELS];

    xw_ctrl #(
        .VA_W  (VA_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .PTE_W (PTE_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .dir_base    (dir_base),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data),
        .state       (state),
        .va_q        (va_q),
        .dir_frame_q (dir_frame_q),
        .tbl_frame_q (tbl_frame_q),
        .done        (done),
        .fault       (fault),
        .paddr       (paddr)
    );

    // Level 0 is the directory, level 1 the second-level table.
    assign lvl_frame[0] = dir_frame_q;
    assign lvl_frame[1] = tbl_frame_q;
    assign lvl_idx[0]   = va_q[VA_W-1 -: IDX_W];
    assign lvl_idx[1]   = va_q[OFF_W +: IDX_W];

    // One entry-address former per table level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        xw_entry_addr #(
            .IDX_W (IDX_W),
            .OFF_W (OFF_W),
            .PA_W  (PA_W)
        ) u_addr (
            .frame (lvl_frame[g]),
            .idx   (lvl_idx[g]),
            .addr  (lvl_addr[g])
        );
    end

    // Drive the read port and the ready flag from the walk phase.
    always_comb begin
        req_ready = (state == WS_IDLE);
        rd_en     = (state != WS_IDLE);
        rd_addr   = (state == WS_TBL) ? lvl_addr[1] : lvl_addr[0];
    end
endmodule

// File: rtl/xw_chk.sv
// Module: xw_chk
// Property checker for xlate_walker, attached through the bind below.
// Assumes it sees the top-level ports of the walker it is bound to.
module xw_chk #(
    parameter int OFF_W = 6,
    parameter int PA_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             rd_en,
    input logic [PA_W-1:0]  rd_addr,
    input logic             rd_ack,
    input logic             rd_msb,
    input logic             done,
    input logic             fault,
    input logic [PA_W-1:0]  paddr
);
    logic [OFF_W-1:0] off_q;

    // Remember the page offset of the request most recently taken.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_off;
    end

    AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !rd_addr[0]); // R3
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ack) |=> (rd_en && $stable(rd_addr))); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (paddr[OFF_W-1:0] == off_q)); // R6
    AST_STOP_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_ack && !rd_msb) |=> !rd_en); // R7
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (paddr == '0)); // R7
    AST_FAULT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done); // R9
    AST_PADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(paddr)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind xlate_walker xw_chk #(
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .rd_msb    (rd_data[PTE_W-1]),
    .done      (done),
    .fault     (fault),
    .paddr     (paddr)
);

// File: tb/test_xlate_walker.sv
// Bench for xlate_walker: a behavioural reference model compared on every
// clock, plus directed and random walks over a byte-array memory.
module test_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic [9:0]  dir_base = '0;
    logic        req_ready;
    logic        rd_en;
    logic [9:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        done;
    logic        fault;
    logic [9:0]  paddr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int cur_lat = 0;
    int wcnt = 0;
    logic [7:0] mem [1024];

    xlate_walker i_xlate_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .dir_base(dir_base), .req_ready(req_ready), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .fault(fault), .paddr(paddr)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int word_at(input int a);
        return {mem[a % 1024], mem[(a + 1) % 1024]};
    endfunction

    task automatic put_word(input int a, input int w);
        mem[a % 1024]       = w[15:8];
        mem[(a + 1) % 1024] = w[7:0];
    endtask

    // Reference translation straight from the requirements.
    task automatic translate(input int va, input int base, output int pa, output int flt);
        int de, te;
        de = word_at((base & 'h3C0) + 2 * ((va >> 11) & 31));
        if (!de[15]) begin pa = 0; flt = 1; return; end
        te = word_at(((de & 15) << 6) + 2 * ((va >> 6) & 31));
        if (!te[15]) begin pa = 0; flt = 1; return; end
        pa = ((te & 15) << 6) | (va & 63);
        flt = 0;
    endtask

    // Cycle model: phase 0 idle, 1 directory read, 2 table read.
    int m_ph = 0, m_va = 0, m_base = 0, m_tbase = 0, m_pa = 0;
    int m_done = 0, m_fault = 0, m_prev_done = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pa = 0; m_done = 0; m_fault = 0; m_prev_done = 0;
        end else begin
            m_prev_done = m_done;
            m_done = 0; m_fault = 0;
            case (m_ph)
                0: if (req_valid) begin
                    m_va = req_vaddr; m_base = dir_base & 'h3C0; m_ph = 1;
                end
                1: if (rd_ack) begin
                    if (rd_data[15]) begin m_tbase = (rd_data & 15) << 6; m_ph = 2; end
                    else begin m_done = 1; m_fault = 1; m_pa = 0; m_ph = 0; end
                end
                default: if (rd_ack) begin
                    m_done = 1; m_ph = 0;
                    if (rd_data[15]) m_pa = ((rd_data & 15) << 6) | (m_va & 63);
                    else begin m_fault = 1; m_pa = 0; end
                end
            endcase
        end
    end

    // Compare against the model, then act as the memory.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "req_ready", req_ready, m_ph == 0);
            chk("R4", "rd_en", rd_en, m_ph != 0);
            if (m_ph == 1) chk("R3", "dir rd_addr", rd_addr, m_base + 2 * ((m_va >> 11) & 31));
            if (m_ph == 2) chk("R5", "tbl rd_addr", rd_addr, m_tbase + 2 * ((m_va >> 6) & 31));
            chk(m_prev_done ? "R10" : "R6", "done", done, m_done);
            chk("R7", "fault", fault, m_fault);
            chk("R9", "paddr", paddr, m_pa);
            if (rd_en) begin
                if (wcnt >= cur_lat) begin
                    rd_ack = 1'b1; rd_data = word_at(rd_addr); wcnt = 0;
                end else begin
                    rd_ack = 1'b0; rd_data = 16'hDEAD; wcnt++;
                end
            end else begin
                rd_ack = 1'b0; wcnt = 0;
            end
        end else begin
            rd_ack = 1'b0;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic walk(input int va, input int base, input int lat, input bit hold,
                        input string tag);
        int exp_pa, exp_flt, n;
        translate(va, base, exp_pa, exp_flt);
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        cur_lat = lat;
        req_valid = 1'b1; req_vaddr = va[15:0]; dir_base = base[9:0];
        @(negedge clk);
        if (hold) begin req_vaddr = ~va[15:0]; dir_base = ~base[9:0]; end
        else req_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        req_valid = 1'b0;
        chk(tag, "walk fault", fault, exp_flt);
        chk(tag, "walk paddr", paddr, exp_pa);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", "req_ready in reset", req_ready, 1);
        chk("R1", "rd_en in reset", rd_en, 0);
        chk("R1", "done/fault in reset", {done, fault}, 0);
        chk("R1", "paddr in reset", paddr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {req_ready, rd_en, done}, 3'b100);

        // Directed tables.
        put_word('h3CC, 'h800C);
        put_word('h30C, 'h8007);
        walk('h3184, 'h3C0, 0, 0, "R6");
        chk("R6", "example paddr", paddr, 'h1C4);
        walk('h3184, 'h3C5, 1, 0, "R3");
        chk("R3", "base low bits ignored", paddr, 'h1C4);
        walk((7 << 11) | 5, 'h3C0, 2, 0, "R7");
        walk((6 << 11) | (7 << 6) | 5, 'h3C0, 0, 0, "R7");
        walk('h3184, 'h3C0, 3, 1, "R2");
        chk("R2", "held request ignored", paddr, 'h1C4);
        put_word('h03E, 'h8001);
        put_word('h07E, 'h800F);
        walk('hFFFF, 'h000, 1, 0, "R5");
        chk("R5", "top indices", paddr, 'h3FF);
        put_word('h000, 'h8002);
        put_word('h080, 'h8009);
        walk('h0000, 'h000, 0, 0, "R5");
        chk("R5", "zero indices", paddr, 'h240);
        put_word('h100, 'hFFF3);
        put_word('h0C2, 'hC00A);
        walk((0 << 11) | (1 << 6) | 'h2A, 'h100, 2, 0, "R8");
        chk("R8", "reserved bits ignored", paddr, 'h2AA);

        // Random memory, random requests.
        for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
        for (int k = 0; k < 300; k++) begin
            int va, base, lat;
            bit hold;
            va = int'($urandom) & 'hFFFF;
            base = int'($urandom) & 'h3FF;
            lat = int'($urandom_range(0, 3));
            hold = 1'($urandom);
            walk(va, base, lat, hold, "R6");
        end
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule